// File: doc/BRIEF.md
# Two-Pass Multicast Copy Planner

This block prepares the routing headers for a multicast cell that crosses a self-routing banyan fabric with wrap-around links twice. A source port streams in its destination list, one address per beat, in strictly ascending order. The planner then produces two things. The first is a single cube header for the copy pass, made of routing bits and don't-care bits, which fans the cell out onto an aligned block of consecutive fabric outputs. The second is a route-pass table, indexed by offset inside that block, that gives each recirculated copy either a unicast destination or an idle mark.

The block is the smallest power-of-two aligned block that holds d copies. Copy number l is sent to the l-th smallest destination, so the active inputs of the second pass are contiguous and their targets are monotone, and the fabric does not block. The upper address bits of the block come from a configuration input. A list of one address skips the copy pass and yields a plain unicast header. A list whose addresses are not strictly ascending yields an error instead of a plan.

The controller is a five-state machine:
- `ST_IDLE` is the state after reset.
- `ST_LOAD` collects beats.
- `ST_CALC` is a single compute cycle.
- `ST_PLAN` holds a valid plan.
- `ST_FAIL` holds an error.

Transitions:
- From `ST_IDLE`, `ST_PLAN` or `ST_FAIL`, a beat moves the machine to `ST_LOAD`. If that beat is also the final beat, the machine moves to `ST_CALC` instead.
- From `ST_LOAD`, the final beat moves the machine to `ST_CALC`.
- From `ST_CALC`, the machine goes to `ST_PLAN` when the order check passed and to `ST_FAIL` when it did not.

Top module: `mcast_copy_planner`

## Requirements
- R1: After reset, `in_ready` is 1, while `plan_valid`, `plan_err` and `copy_skip` are 0.
- R2: A beat is taken on every rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 only during the single compute cycle that follows the edge taking the final beat (`in_last`=1).
- R3: `plan_valid` (or `plan_err`) becomes 1 at the rising edge that follows the edge taking the final beat. It is 0 during the compute cycle.
- R4: For d of 2 or more, bit i of `copy_mask` is 1 exactly for i < k, where k is the smallest integer with d ≤ 2^k. A 1 in the mask means don't-care, or broadcast, at that fabric stage.
- R5: For d of 2 or more, `copy_route` equals `cfg_base` with its low k bits forced to 0. This value is the start output s of the copy block. `cfg_base` is sampled in the compute cycle.
- R6: For each offset l < d, reading the table at `rd_off`=l gives `rd_used`=1 and `rd_dest`=D_l, the l-th destination in ascending order.
- R7: For each offset l ≥ d, `rd_used` is 0, even if a previous, longer list had filled that offset.
- R8: For d=1, `copy_skip` is 1, `copy_route` equals the only destination, and `copy_mask` is 0.
- R9: If any beat of a list is less than or equal to the beat before it, the result is `plan_err`=1 with `plan_valid`=0.
- R10: A finished plan or error, together with the header outputs, is held until the first beat of the next list is taken. That edge clears `plan_valid` and `plan_err`.
- R11: For d of 2 or more, `copy_skip` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Destination beat present |
| in_ready | output | 1 | Planner accepts a beat |
| in_addr | input | ADDR_W | Destination address of the beat |
| in_last | input | 1 | Beat is the final one of the list |
| cfg_base | input | ADDR_W | Selects the upper bits of the copy block |
| plan_valid | output | 1 | Plan outputs are valid |
| plan_err | output | 1 | List was rejected |
| copy_route | output | ADDR_W | Copy-pass routing bits (start output s, or the unicast target when skipped) |
| copy_mask | output | ADDR_W | Copy-pass don't-care bits |
| copy_skip | output | 1 | Copy pass not needed (d=1) |
| rd_off | input | ADDR_W | Route-table offset to read |
| rd_used | output | 1 | Offset carries a copy in the route pass |
| rd_dest | output | ADDR_W | Unicast destination for the offset |

## Verification
The result arrives on a fixed schedule. After the edge that takes the final beat there is exactly one compute cycle, in which `in_ready` and `plan_valid` are 0. The bench checks that cycle at the following falling edge. It then checks the header and status one falling edge after the next rising edge. The route table is combinational on `rd_off` once the last beat has been stored, so the bench sweeps every offset a few nanoseconds after changing it, while the plan is held. The check that results are held samples three idle cycles later. The check that results are cleared samples just after the first beat of the next list is taken.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CALC,
        ST_PLAN,
        ST_FAIL
    } plan_state_t;
endpackage

// File: rtl/mcp_dest_store.sv
module mcp_dest_store #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_first,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_off,
    output logic [CNT_W-1:0]  count,
    output logic              order_bad,
    output logic              rd_used,
    output logic [ADDR_W-1:0] rd_dest,
    output logic [ADDR_W-1:0] first_dest
);
    localparam int IDX_W = CNT_W - 1;

    logic [ADDR_W-1:0] entries [DEPTH];
    logic [DEPTH-1:0]  used;
    logic [ADDR_W-1:0] prev_addr;
    logic [IDX_W-1:0]  wr_idx;
    logic              room;

    assign wr_idx = wr_first ? '0 : count[IDX_W-1:0];
    assign room   = wr_first || (count < CNT_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            order_bad <= 1'b0;
            used      <= '0;
            prev_addr <= '0;
        end else if (wr_en) begin
            prev_addr <= wr_addr;
            if (wr_first) begin
                count     <= CNT_W'(1);
                order_bad <= 1'b0;
                used      <= DEPTH'(1);
            end else begin
                if (wr_addr <= prev_addr || !room) begin
                    order_bad <= 1'b1;
                end
                if (room) begin
                    count        <= count + CNT_W'(1);
                    used[wr_idx] <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && room) begin
            entries[wr_idx] <= wr_addr;
        end
    end

    assign rd_used    = used[rd_off];
    assign rd_dest    = entries[rd_off];
    assign first_dest = entries[0];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R6
endmodule

// File: rtl/mcp_cube_calc.sv
module mcp_cube_calc #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] first_dest,
    output logic [ADDR_W-1:0] route,
    output logic [ADDR_W-1:0] mask,
    output logic              skip
);
    // Bit i lies inside the block when 2^i < d, i.e. i < k.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign mask[i] = (count > (CNT_W'(1) << i));
    end

    assign skip  = (count == CNT_W'(1));
    assign route = skip ? first_dest : (base & ~mask);
endmodule

// File: rtl/mcp_plan_fsm.sv
module mcp_plan_fsm
    import mcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic order_bad,
    output logic in_ready,
    output logic wr_en,
    output logic wr_first,
    output logic latch_en,
    output logic plan_valid,
    output logic plan_err
);
    plan_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_PLAN, ST_FAIL: begin
                if (in_valid) state_nx = in_last ? ST_CALC : ST_LOAD;
            end
            ST_LOAD: begin
                if (in_valid && in_last) state_nx = ST_CALC;
            end
            ST_CALC: begin
                state_nx = order_bad ? ST_FAIL : ST_PLAN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready   = 1'b1;
        wr_first   = 1'b0;
        latch_en   = 1'b0;
        plan_valid = 1'b0;
        plan_err   = 1'b0;
        unique case (state)
            ST_IDLE: wr_first = 1'b1;
            ST_LOAD: wr_first = 1'b0;
            ST_CALC: begin
                in_ready = 1'b0;
                latch_en = !order_bad;
            end
            ST_PLAN: begin
                wr_first   = 1'b1;
                plan_valid = 1'b1;
            end
            ST_FAIL: begin
                wr_first = 1'b1;
                plan_err = 1'b1;
            end
            default: in_ready = 1'b0;
        endcase
        wr_en = in_valid && in_ready;
    end

    AST_CALC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> (state != ST_CALC)); // R2
    AST_RESULT_AFTER_CALC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> (plan_valid || plan_err)); // R3
    AST_PLAN_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(plan_valid && plan_err)); // R9
endmodule

// File: rtl/mcast_copy_planner.sv
module mcast_copy_planner #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_last,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              plan_valid,
    output logic              plan_err,
    output logic [ADDR_W-1:0] copy_route,
    output logic [ADDR_W-1:0] copy_mask,
    output logic              copy_skip,
    input  logic [ADDR_W-1:0] rd_off,
    output logic              rd_used,
    output logic [ADDR_W-1:0] rd_dest
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;

    logic              wr_en, wr_first, latch_en, order_bad;
    logic [CNT_W-1:0]  d_count;
    logic [ADDR_W-1:0] first_dest, calc_route, calc_mask;
    logic              calc_skip;

    mcp_plan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .order_bad  (order_bad),
        .in_ready   (in_ready),
        .wr_en      (wr_en),
        .wr_first   (wr_first),
        .latch_en   (latch_en),
        .plan_valid (plan_valid),
        .plan_err   (plan_err)
    );

    mcp_dest_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_first   (wr_first),
        .wr_addr    (in_addr),
        .rd_off     (rd_off),
        .count      (d_count),
        .order_bad  (order_bad),
        .rd_used    (rd_used),
        .rd_dest    (rd_dest),
        .first_dest (first_dest)
    );

    mcp_cube_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_calc (
        .count      (d_count),
        .base       (cfg_base),
        .first_dest (first_dest),
        .route      (calc_route),
        .mask       (calc_mask),
        .skip       (calc_skip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copy_route <= '0;
            copy_mask  <= '0;
            copy_skip  <= 1'b0;
        end else if (latch_en) begin
            copy_route <= calc_route;
            copy_mask  <= calc_mask;
            copy_skip  <= calc_skip;
        end
    end

    AST_BLOCK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && !copy_skip) |-> (({1'b0, copy_mask} + CNT_W'(1)) >= d_count)); // R4
    AST_BLOCK_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && !copy_skip) |-> ((({1'b0, copy_mask} + CNT_W'(1)) >> 1) < d_count)); // R4
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && !copy_skip) |-> ((copy_route & copy_mask) == '0)); // R5
    AST_SKIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && copy_skip) |-> (d_count == CNT_W'(1) && copy_mask == '0)); // R8
    AST_HEADER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && $past(plan_valid)) |-> ($stable(copy_route) && $stable(copy_mask))); // R10
endmodule

// File: tb/mcast_copy_planner_test.sv
module mcast_copy_planner_test;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic          in_last = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          plan_valid, plan_err, copy_skip, rd_used;
    logic [AW-1:0] copy_route, copy_mask, rd_dest;
    logic [AW-1:0] rd_off = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int lst [N+1];

    mcast_copy_planner #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_last(in_last), .cfg_base(cfg_base),
        .plan_valid(plan_valid), .plan_err(plan_err), .copy_route(copy_route),
        .copy_mask(copy_mask), .copy_skip(copy_skip), .rd_off(rd_off),
        .rd_used(rd_used), .rd_dest(rd_dest)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mask(input int d);
        int k = 0;
        while ((1 << k) < d) k++;
        return (1 << k) - 1;
    endfunction

    task automatic run_list(input int n, input int base);
        bit bad = 0;
        int m;
        cfg_base = AW'(base);
        for (int i = 1; i < n; i++) if (lst[i] <= lst[i-1]) bad = 1;
        for (int i = 0; i < n; i++) begin
            chk(in_ready == 1'b1, "R2 ready during load", int'(in_ready), 1);
            in_valid = 1'b1;
            in_addr  = AW'(lst[i]);
            in_last  = (i == n - 1);
            @(posedge clk); @(negedge clk);
            if (i == 0 && n > 1)
                chk(plan_valid == 1'b0 && plan_err == 1'b0, "R10 cleared by first beat",
                    int'(plan_valid | plan_err), 0);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        chk(in_ready == 1'b0, "R2 compute cycle", int'(in_ready), 0);
        chk(plan_valid == 1'b0, "R3 not yet valid", int'(plan_valid), 0);
        @(posedge clk); @(negedge clk);
        if (bad) begin
            chk(plan_err == 1'b1 && plan_valid == 1'b0, "R9 error flag",
                int'({plan_err, plan_valid}), 2);
            return;
        end
        chk(plan_valid == 1'b1 && plan_err == 1'b0, "R3 plan valid",
            int'({plan_valid, plan_err}), 2);
        if (n == 1) begin
            chk(copy_skip == 1'b1, "R8 skip", int'(copy_skip), 1);
            chk(int'(copy_route) == lst[0], "R8 route", int'(copy_route), lst[0]);
            chk(copy_mask == '0, "R8 mask", int'(copy_mask), 0);
        end else begin
            m = exp_mask(n);
            chk(int'(copy_mask) == m, "R4 mask", int'(copy_mask), m);
            chk(int'(copy_route) == (base & ~m & (N - 1)), "R5 start", int'(copy_route),
                base & ~m & (N - 1));
            chk(copy_skip == 1'b0, "R11 no skip", int'(copy_skip), 0);
        end
        for (int l = 0; l < N; l++) begin
            rd_off = AW'(l);
            #1;
            if (l < n) begin
                chk(rd_used == 1'b1, "R6 used", int'(rd_used), 1);
                chk(int'(rd_dest) == lst[l], "R6 dest", int'(rd_dest), lst[l]);
            end else begin
                chk(rd_used == 1'b0, "R7 idle offset", int'(rd_used), 0);
            end
        end
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL R2 watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int n, route0;
        logic [15:0] bits;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
        chk(plan_valid == 1'b0 && plan_err == 1'b0 && copy_skip == 1'b0, "R1 flags",
            int'({plan_valid, plan_err, copy_skip}), 0);

        // Example list: block 1xxx, offset 7 idle
        lst[0]=3; lst[1]=4; lst[2]=6; lst[3]=7; lst[4]=9; lst[5]=11; lst[6]=13;
        run_list(7, 8);
        run_list(7, 15);
        // R10: header held while idle
        route0 = int'(copy_route);
        repeat (3) @(negedge clk);
        chk(plan_valid == 1'b1 && int'(copy_route) == route0, "R10 held",
            int'(copy_route), route0);
        // full list
        for (int i = 0; i < N; i++) lst[i] = i;
        run_list(N, 5);
        // short list after long: stale offsets idle
        lst[0]=2; lst[1]=14;
        run_list(2, 13);
        lst[0]=9;
        run_list(1, 3);
        lst[0]=5; lst[1]=5;
        run_list(2, 0);
        lst[0]=9; lst[1]=2; lst[2]=12;
        run_list(3, 6);
        lst[0]=1; lst[1]=4; lst[2]=8;
        run_list(3, 10);

        for (int t = 0; t < 60; t++) begin
            bits = 16'($urandom);
            if (bits == 0) bits[$urandom % N] = 1'b1;
            n = 0;
            for (int b = 0; b < N; b++) if (bits[b]) begin lst[n] = b; n++; end
            if (n >= 2 && ($urandom % 6) == 0) begin
                int j = 1 + ($urandom % (n - 1));
                lst[j] = lst[j-1];
            end
            run_list(n, int'($urandom % N));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule